// File: doc/BRIEF.md
# Receive Data-Block Quadlet Demultiplexer

This block sits behind the isochronous packet parser on the receive side of an audio stream. It takes the payload quadlets one per cycle and sorts each one by its position inside the current data block. A programmable number of leading quadlets is thrown away. The next quadlets are audio samples, one per channel in rising channel order. When MIDI ports are configured, one MIDI quadlet follows the audio. Every audio sample leaves with its channel index and a strobe. The MIDI quadlet leaves on a separate strobe.

Three configuration inputs set the block layout: the skip count, the audio channel count and the MIDI port count. The block samples them only at a block boundary, so a change in the middle of a block does not disturb that block. A block-start flag from the parser forces the position back to zero. Once a block has run to its full length, the next quadlet opens a new block without any flag. The stream runs only while the enable input is set and the isochronous channel input holds a legal channel number (0 to 63). Any other value, including all-ones (-1), marks the stream as unused.

Top module: `rx_block_demux`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `aud_valid` and `midi_valid` are 0.
- R2: In each block, the first `skip_cnt` quadlets (positions 0 to skip_cnt-1) produce no strobe.
- R3: The quadlet at position skip_cnt+k, for k below `audio_cnt`, comes out on `aud_data` unchanged, with `aud_valid`=1 and `aud_chan`=k.
- R4: When `midi_ports` is between 1 and 8, the quadlet at position skip_cnt+audio_cnt comes out on `midi_data` with `midi_valid`=1. When `midi_ports` is 0, no MIDI strobe is produced.
- R5: A block is skip_cnt + audio_cnt + (midi_ports≠0 ? 1 : 0) quadlets long. The quadlet after the last one is position 0 of a new block, with no `in_first` needed. Quadlets at or beyond a zero-length layout produce nothing.
- R6: An accepted quadlet with `in_first`=1 is taken as position 0, even in the middle of a block.
- R7: After reset, and after any time the stream was stopped, quadlets produce nothing until one arrives with `in_first`=1.
- R8: A change to `skip_cnt`, `audio_cnt` or `midi_ports` applies from the next position-0 quadlet. It does not apply in the middle of a block.
- R9: While `stream_en` is 0, no strobe is produced. Clearing it drops the current block and returns the block to the idle state of R7.
- R10: An `iso_chan` value above 63 (including 8'hFF, meaning -1) acts like a cleared enable, as in R9.
- R11: Each strobe rises one clock after the edge that accepted the quadlet. A cycle with `in_valid`=0 produces no strobe.
- R12: `aud_valid` and `midi_valid` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_en | input | 1 | Global streaming enable |
| iso_chan | input | 8 | Isochronous channel; legal values 0..63 |
| skip_cnt | input | 4 | Leading quadlets to discard per block |
| audio_cnt | input | 6 | Audio channels per block (0..32) |
| midi_ports | input | 4 | MIDI port count (0..8) |
| in_valid | input | 1 | Quadlet present on in_data |
| in_first | input | 1 | Quadlet is the first of a block |
| in_data | input | 32 | Payload quadlet |
| aud_valid | output | 1 | Audio sample strobe |
| aud_chan | output | 5 | Channel index of the audio sample |
| aud_data | output | 32 | Audio sample quadlet |
| midi_valid | output | 1 | MIDI quadlet strobe |
| midi_data | output | 32 | MIDI quadlet |

## Verification
The properties assume that the configuration inputs stay inside their stated ranges. They also assume that `in_first` is only meaningful together with `in_valid`. The channel-order property further relies on every audio strobe coming from the sequence that R3 describes. The stimulus keeps every configuration value within its range, including the extremes 0/0/0 and 15/32/8. It changes configuration, enable and channel only through the same per-cycle driver that feeds the quadlets, so the reference model and the design always see identical inputs.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    // Role of one quadlet inside a data block
    typedef enum logic [1:0] {
        SLOT_SKIP  = 2'd0,
        SLOT_AUDIO = 2'd1,
        SLOT_MIDI  = 2'd2,
        SLOT_NONE  = 2'd3
    } slot_e;

endpackage

// File: rtl/rbd_cfg_hold.sv
// Captures the block layout at a boundary and presents the layout in force
module rbd_cfg_hold #(
    parameter int SKIP_W = 4,
    parameter int AUD_W  = 6,
    parameter int MIDI_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              use_live,
    input  logic [SKIP_W-1:0] live_skip,
    input  logic [AUD_W-1:0]  live_aud,
    input  logic [MIDI_W-1:0] live_midi,
    output logic [SKIP_W-1:0] eff_skip,
    output logic [AUD_W-1:0]  eff_aud,
    output logic [MIDI_W-1:0] eff_midi
);

    typedef struct packed {
        logic [SKIP_W-1:0] skip;
        logic [AUD_W-1:0]  aud;
        logic [MIDI_W-1:0] midi;
    } layout_t;

    layout_t held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (load) begin
            held_d.skip = live_skip;
            held_d.aud  = live_aud;
            held_d.midi = live_midi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign eff_skip = use_live ? live_skip : held_q.skip;
    assign eff_aud  = use_live ? live_aud  : held_q.aud;
    assign eff_midi = use_live ? live_midi : held_q.midi;

endmodule

// File: rtl/rbd_slot_decode.sv
// Classifies a block position against the layout in force
module rbd_slot_decode
    import rbd_pkg::*;
#(
    parameter int SKIP_W = 4,
    parameter int AUD_W  = 6,
    parameter int MIDI_W = 4,
    parameter int POS_W  = 6,
    parameter int CHI_W  = 5
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [SKIP_W-1:0] skip,
    input  logic [AUD_W-1:0]  aud,
    input  logic [MIDI_W-1:0] midi,
    output slot_e             slot,
    output logic [CHI_W-1:0]  chan_idx,
    output logic              last
);

    localparam int LW = POS_W + 1;

    logic [LW-1:0] pos_ext, skip_end, aud_end, blk_len, pos_nx;
    logic          has_midi;

    always_comb begin
        has_midi = (midi != '0);
        pos_ext  = LW'(pos);
        skip_end = LW'(skip);
        aud_end  = skip_end + LW'(aud);
        blk_len  = aud_end + LW'(has_midi);
        pos_nx   = pos_ext + LW'(1);
        last     = (pos_nx >= blk_len);
        chan_idx = CHI_W'(pos_ext - skip_end);
        if (pos_ext < skip_end)                   slot = SLOT_SKIP;
        else if (pos_ext < aud_end)               slot = SLOT_AUDIO;
        else if (pos_ext == aud_end && has_midi)  slot = SLOT_MIDI;
        else                                      slot = SLOT_NONE;
    end

endmodule

// File: rtl/rx_block_demux.sv
module rx_block_demux
    import rbd_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MAX_SKIP  = 15,
    parameter int MAX_AUDIO = 32,
    parameter int MAX_MIDI  = 8,
    parameter int CHAN_W    = 8,
    parameter int MAX_ISO   = 63,
    localparam int SKIP_W   = $clog2(MAX_SKIP + 1),
    localparam int AUD_W    = $clog2(MAX_AUDIO + 1),
    localparam int MIDI_W   = $clog2(MAX_MIDI + 1),
    localparam int CHI_W    = (MAX_AUDIO > 1) ? $clog2(MAX_AUDIO) : 1,
    localparam int POS_W    = $clog2(MAX_SKIP + MAX_AUDIO + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_en,
    input  logic [CHAN_W-1:0] iso_chan,
    input  logic [SKIP_W-1:0] skip_cnt,
    input  logic [AUD_W-1:0]  audio_cnt,
    input  logic [MIDI_W-1:0] midi_ports,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [DATA_W-1:0] in_data,
    output logic              aud_valid,
    output logic [CHI_W-1:0]  aud_chan,
    output logic [DATA_W-1:0] aud_data,
    output logic              midi_valid,
    output logic [DATA_W-1:0] midi_data
);

    typedef struct packed {
        logic              run;
        logic [POS_W-1:0]  pos;
        logic              aud_v;
        logic [CHI_W-1:0]  aud_ch;
        logic [DATA_W-1:0] aud_dat;
        logic              midi_v;
        logic [DATA_W-1:0] midi_dat;
    } state_t;

    state_t st_d, st_q;

    logic              chan_ok, active, take, boundary, last;
    logic [POS_W-1:0]  pos_cur;
    logic [SKIP_W-1:0] eff_skip;
    logic [AUD_W-1:0]  eff_aud;
    logic [MIDI_W-1:0] eff_midi;
    logic [CHI_W-1:0]  chan_idx;
    slot_e             slot;

    assign chan_ok  = (iso_chan <= CHAN_W'(MAX_ISO));
    assign active   = stream_en && chan_ok;
    assign take     = active && in_valid && (in_first || st_q.run);
    assign boundary = in_first || (st_q.pos == '0);
    assign pos_cur  = in_first ? '0 : st_q.pos;

    rbd_cfg_hold #(
        .SKIP_W(SKIP_W), .AUD_W(AUD_W), .MIDI_W(MIDI_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take && boundary),
        .use_live (boundary),
        .live_skip(skip_cnt),
        .live_aud (audio_cnt),
        .live_midi(midi_ports),
        .eff_skip (eff_skip),
        .eff_aud  (eff_aud),
        .eff_midi (eff_midi)
    );

    rbd_slot_decode #(
        .SKIP_W(SKIP_W), .AUD_W(AUD_W), .MIDI_W(MIDI_W),
        .POS_W(POS_W), .CHI_W(CHI_W)
    ) u_dec (
        .pos     (pos_cur),
        .skip    (eff_skip),
        .aud     (eff_aud),
        .midi    (eff_midi),
        .slot    (slot),
        .chan_idx(chan_idx),
        .last    (last)
    );

    always_comb begin
        st_d        = st_q;
        st_d.aud_v  = 1'b0;
        st_d.midi_v = 1'b0;
        if (!active) begin
            st_d.run = 1'b0;
            st_d.pos = '0;
        end else if (take) begin
            st_d.run = 1'b1;
            st_d.pos = last ? '0 : pos_cur + POS_W'(1);
            case (slot)
                SLOT_AUDIO: begin
                    st_d.aud_v   = 1'b1;
                    st_d.aud_ch  = chan_idx;
                    st_d.aud_dat = in_data;
                end
                SLOT_MIDI: begin
                    st_d.midi_v   = 1'b1;
                    st_d.midi_dat = in_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign aud_valid  = st_q.aud_v;
    assign aud_chan   = st_q.aud_ch;
    assign aud_data   = st_q.aud_dat;
    assign midi_valid = st_q.midi_v;
    assign midi_data  = st_q.midi_dat;

endmodule

// File: rtl/rx_block_demux_chk.sv
module rx_block_demux_chk #(
    parameter int CHAN_W  = 8,
    parameter int CHI_W   = 5,
    parameter int MIDI_W  = 4,
    parameter int MAX_ISO = 63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stream_en,
    input logic [CHAN_W-1:0] iso_chan,
    input logic              in_valid,
    input logic              aud_valid,
    input logic [CHI_W-1:0]  aud_chan,
    input logic              midi_valid,
    input logic [MIDI_W-1:0] eff_midi
);

    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(aud_valid && midi_valid));

    a_r9_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stream_en) |-> (!aud_valid && !midi_valid));

    a_r10_chan_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(iso_chan) > CHAN_W'(MAX_ISO)) |-> (!aud_valid && !midi_valid));

    a_r11_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        (aud_valid || midi_valid) |-> $past(in_valid));

    a_r4_midi_present: assert property (@(posedge clk) disable iff (!rst_n)
        midi_valid |-> ($past(eff_midi) != '0));

    a_r3_chan_order: assert property (@(posedge clk) disable iff (!rst_n)
        (aud_valid && $past(aud_valid)) |->
            (aud_chan == '0 || aud_chan == $past(aud_chan) + CHI_W'(1)));

endmodule

bind rx_block_demux rx_block_demux_chk #(
    .CHAN_W(CHAN_W), .CHI_W(CHI_W), .MIDI_W(MIDI_W), .MAX_ISO(MAX_ISO)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stream_en (stream_en),
    .iso_chan  (iso_chan),
    .in_valid  (in_valid),
    .aud_valid (aud_valid),
    .aud_chan  (aud_chan),
    .midi_valid(midi_valid),
    .eff_midi  (eff_midi)
);

// File: tb/rx_block_demux_test.sv
module rx_block_demux_test;

    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        stream_en = 1'b0;
    logic [7:0]  iso_chan = '0;
    logic [3:0]  skip_cnt = '0;
    logic [5:0]  audio_cnt = '0;
    logic [3:0]  midi_ports = '0;
    logic        in_valid = 1'b0;
    logic        in_first = 1'b0;
    logic [31:0] in_data = '0;
    logic        aud_valid, midi_valid;
    logic [4:0]  aud_chan;
    logic [31:0] aud_data, midi_data;

    rx_block_demux uut (
        .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .iso_chan(iso_chan),
        .skip_cnt(skip_cnt), .audio_cnt(audio_cnt), .midi_ports(midi_ports),
        .in_valid(in_valid), .in_first(in_first), .in_data(in_data),
        .aud_valid(aud_valid), .aud_chan(aud_chan), .aud_data(aud_data),
        .midi_valid(midi_valid), .midi_data(midi_data)
    );

    // pending inputs, applied together with each quadlet
    bit p_rst = 0, p_en = 0;
    int p_chan = 0, p_skip = 0, p_aud = 0, p_midi = 0;

    // reference model state
    bit m_run = 0;
    int m_pos = 0, m_s = 0, m_a = 0, m_m = 0;
    bit e_av = 0, e_mv = 0;
    int e_ch = 0;
    logic [31:0] e_ad = '0, e_md = '0;
    string e_tag = "R1";

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic check_outputs();
        checks++;
        if (aud_valid !== e_av || midi_valid !== e_mv ||
            (e_av && (aud_chan !== e_ch[4:0] || aud_data !== e_ad)) ||
            (e_mv && midi_data !== e_md)) begin
            errors++;
            $display("FAIL %s: got a=%0b ch=%0d d=%h m=%0b md=%h exp a=%0b ch=%0d d=%h m=%0b md=%h",
                     e_tag, aud_valid, aud_chan, aud_data, midi_valid, midi_data,
                     e_av, e_ch, e_ad, e_mv, e_md);
        end
        checks++;
        if (aud_valid && midi_valid) begin // R12
            errors++;
            $display("FAIL R12: got both strobes 1 exp at most one");
        end
    endtask

    task automatic model(bit v, bit f, logic [31:0] d);
        int p, len;
        string over, base;
        e_av = 0; e_mv = 0;
        if (!p_rst) begin
            m_run = 0; m_pos = 0; m_s = 0; m_a = 0; m_m = 0;
            e_tag = "R1";
            return;
        end
        if (!p_en || p_chan > 63) begin
            m_run = 0; m_pos = 0;
            e_tag = p_en ? "R10" : "R9";
            return;
        end
        if (!v) begin e_tag = "R11"; return; end
        if (!f && !m_run) begin e_tag = "R7"; return; end
        over = "";
        if (f && m_run && m_pos != 0) over = "R6";
        else if (!f && m_pos != 0 &&
                 (p_skip != m_s || p_aud != m_a || p_midi != m_m)) over = "R8";
        else if (!f && m_pos == 0) over = "R5";
        if (f || m_pos == 0) begin m_s = p_skip; m_a = p_aud; m_m = p_midi; end
        p = f ? 0 : m_pos;
        len = m_s + m_a + ((m_m > 0) ? 1 : 0);
        if (p < m_s) base = "R2";
        else if (p < m_s + m_a) begin
            e_av = 1; e_ch = p - m_s; e_ad = d; base = "R3";
        end else if (p == m_s + m_a && m_m > 0) begin
            e_mv = 1; e_md = d; base = "R4";
        end else base = "R5";
        m_pos = (p + 1 >= len) ? 0 : p + 1;
        m_run = 1;
        e_tag = (over != "") ? over : base;
    endtask

    task automatic step(bit v, bit f);
        logic [31:0] d;
        d = $urandom;
        @(negedge clk);
        check_outputs();
        rst_n = p_rst; stream_en = p_en; iso_chan = p_chan[7:0];
        skip_cnt = p_skip[3:0]; audio_cnt = p_aud[5:0]; midi_ports = p_midi[3:0];
        in_valid = v; in_first = f; in_data = d;
        model(v, f, d);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            report();
        end
    end

    initial begin
        // R1 reset state
        repeat (3) step(0, 0);
        checks++;
        if (aud_valid !== 1'b0 || midi_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: got a=%0b m=%0b exp 0 0", aud_valid, midi_valid);
        end
        p_rst = 1; p_en = 1; p_chan = 5; p_skip = 2; p_aud = 4; p_midi = 2;
        repeat (3) step(1, 0);                  // R7 no block start yet
        step(1, 1); repeat (20) step(1, 0);     // R2 R3 R4 R5
        repeat (20) step(1'($urandom % 2), 0);  // R11 gaps
        p_skip = 0; p_aud = 3; p_midi = 0;      // R8 mid-block change
        repeat (12) step(1, 0);
        step(1, 1); step(1, 0); step(1, 1);     // R6 realign
        repeat (5) step(1, 0);
        p_en = 0; repeat (2) step(1, 0);        // R9 abort
        p_en = 1; repeat (3) step(1, 0);        // R7 after restart
        step(1, 1); repeat (4) step(1, 0);
        p_chan = 255; repeat (3) step(1, 1);    // R10 -1
        p_chan = 64; step(1, 1);                // R10 out of range
        p_chan = 63; step(1, 1); repeat (5) step(1, 0);
        p_skip = 0; p_aud = 0; p_midi = 0;      // R5 empty layout
        step(1, 1); repeat (3) step(1, 0);
        p_aud = 0; p_midi = 1;                  // R4 midi only
        step(1, 1); repeat (3) step(1, 0);
        p_skip = 15; p_aud = 32; p_midi = 8;    // extremes
        step(1, 1); repeat (60) step(1, 0);
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 50 == 0) begin
                p_skip = $urandom % 16; p_aud = $urandom % 33; p_midi = $urandom % 9;
            end
            if ($urandom % 300 == 0) p_en = !p_en;
            else if (!p_en && $urandom % 5 == 0) p_en = 1;
            if ($urandom % 400 == 0) p_chan = 255;
            else if (p_chan > 63 && $urandom % 5 == 0) p_chan = $urandom % 64;
            step(1'($urandom % 4 != 0), 1'($urandom % 40 == 0));
        end
        step(0, 0); step(0, 0);
        done = 1;
        report();
    end

endmodule